// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port Register Block

This block is the software-facing register layer of a serial port. A 32-bit register bus reaches seven word registers: transmit data, receive data, transmit control, receive control, interrupt enable, interrupt pending and a clock divisor. Received bytes arrive on a valid/ready byte stream and queue in a small receive FIFO. Software drains that FIFO by reading the receive-data register. A write to the transmit-data register sends its low byte out on a byte-stream output with no queueing.

Each control register holds a 3-bit watermark count. The pending register is computed from those counts and from the receive FIFO occupancy. A single level-sensitive interrupt line combines the enable bits with the FIFO state. Bit timing, framing and baud generation belong to a neighbouring block. The divisor is only stored here so that software can read it back.

Top module: `uart_regif`

## Requirements
- R1: A valid read of receive data (offset 0x04) when the FIFO holds bytes returns the oldest byte in bits 7:0, with bits 31:8 zero, and removes that byte. Bytes leave in arrival order.
- R2: A valid read of receive data when the FIFO is empty returns 0x80000000, with bit 31 as the empty flag. It changes no state.
- R3: A valid write to transmit data (offset 0x00) raises tx_valid_o for exactly one cycle, in the cycle after the write edge, with tx_data_o equal to wdata_i[7:0]. A read of transmit data returns 0.
- R4: Transmit control (0x08), receive control (0x0C) and divisor (0x18) store and read back all 32 bits. Interrupt enable (0x10) stores and reads back bits 1:0 only, and its other bits read 0.
- R5: Pending (0x14) bit 0, the transmit watermark, is 1 exactly when transmit-control bits 18:16 are nonzero.
- R6: Pending bit 1, the receive watermark, is 1 exactly when the FIFO occupancy is strictly greater than receive-control bits 18:16.
- R7: irq_o is 1 when enable bit 0 is set, or when enable bit 1 is set and the FIFO is non-empty. irq_o follows register state with no added delay.
- R8: The FIFO holds 8 bytes. While it is full, rx_ready_o is 0, and a byte offered in that state is dropped.
- R9: An access with be_i other than 4'hF, or at an unmapped offset, reads 0 and has no effect: no store, no pop and no transmit. A write to the pending register is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| be_i | input | 4 | Byte enables; only 4'hF is a valid access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational in the access cycle |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_data_i | input | 8 | Incoming byte |
| rx_ready_o | output | 1 | FIFO can accept a byte |
| tx_valid_o | output | 1 | Outgoing byte strobe |
| tx_data_o | output | 8 | Outgoing byte |
| irq_o | output | 1 | Level interrupt |

## Verification
A read or write pointer that slips shows up as bytes out of order or as stale data on the next receive read. Both are caught on the first drain after a fill, including a fill that wraps the pointers. An occupancy count that is off by one shows up at once in pending bit 1 when the watermark is set one below the expected count. It also shows up as rx_ready_o dropping one byte early or late around the eighth push. Decode faults appear in the same cycle, either as read data from the wrong register or as a transmit strobe after an access that should have been ignored. The scoreboard flags any such strobe as unexpected.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_TXDATA = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_RXDATA = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_TXCTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_RXCTRL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_IE     = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_IP     = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_DIV    = 5'h18;

  localparam int unsigned WM_LSB = 16;
  localparam int unsigned WM_W   = 3;

  localparam int unsigned IRQ_TX = 0;
  localparam int unsigned IRQ_RX = 1;
  localparam int unsigned IRQ_N  = 2;

  localparam logic [REG_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + PW'(1);
      if (pop_ok)  rptr_q <= (rptr_q == LAST_PTR) ? '0 : rptr_q + PW'(1);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // storage has no reset; never read while empty
  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= data_i;
  end

  // R8
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  // R1
  fifo_pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> cnt_q == $past(cnt_q) - CW'(1));
  // R8
  fifo_push_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_regif_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic [WM_W-1:0]  tx_wm_i,
  input  logic [WM_W-1:0]  rx_wm_i,
  input  logic [CW-1:0]    rx_count_i,
  input  logic [IRQ_N-1:0] ie_i,
  output logic [IRQ_N-1:0] ip_o,
  output logic             irq_o
);
  always_comb begin
    ip_o         = '0;
    ip_o[IRQ_TX] = (tx_wm_i != '0);
    ip_o[IRQ_RX] = (rx_count_i > CW'(rx_wm_i));
  end

  // rx source fires on any data, not on the watermark
  assign irq_o = ie_i[IRQ_TX] || (ie_i[IRQ_RX] && (rx_count_i != '0));
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(RX_DEPTH + 1);

  logic              acc_ok, wr_ok, rd_ok;
  logic              wr_tx, wr_txc, wr_rxc, wr_ie, wr_div, rd_rx;
  logic [REG_W-1:0]  txctrl_q, rxctrl_q, div_q;
  logic [IRQ_N-1:0]  ie_q, ip;
  logic              tx_valid_q;
  logic [BYTE_W-1:0] tx_data_q;
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [BYTE_W-1:0] fifo_data;
  logic [CW-1:0]     fifo_count;

  assign acc_ok = req_i && (be_i == 4'hF);
  assign wr_ok  = acc_ok && we_i;
  assign rd_ok  = acc_ok && !we_i;

  assign wr_tx  = wr_ok && (addr_i == OFF_TXDATA);
  assign wr_txc = wr_ok && (addr_i == OFF_TXCTRL);
  assign wr_rxc = wr_ok && (addr_i == OFF_RXCTRL);
  assign wr_ie  = wr_ok && (addr_i == OFF_IE);
  assign wr_div = wr_ok && (addr_i == OFF_DIV);
  assign rd_rx  = rd_ok && (addr_i == OFF_RXDATA);

  assign fifo_pop   = rd_rx && !fifo_empty;
  assign rx_ready_o = !fifo_full;
  assign fifo_push  = rx_valid_i && rx_ready_o;

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fifo_push),
    .data_i  (rx_data_i),
    .pop_i   (fifo_pop),
    .data_o  (fifo_data),
    .count_o (fifo_count),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  uart_irq_gen #(.CW(CW)) i_irq_gen (
    .tx_wm_i    (txctrl_q[WM_LSB +: WM_W]),
    .rx_wm_i    (rxctrl_q[WM_LSB +: WM_W]),
    .rx_count_i (fifo_count),
    .ie_i       (ie_q),
    .ip_o       (ip),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txctrl_q   <= '0;
      rxctrl_q   <= '0;
      div_q      <= '0;
      ie_q       <= '0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (wr_txc) txctrl_q <= wdata_i;
      if (wr_rxc) rxctrl_q <= wdata_i;
      if (wr_div) div_q    <= wdata_i;
      if (wr_ie)  ie_q     <= wdata_i[IRQ_N-1:0];
      tx_valid_q <= wr_tx;
      if (wr_tx)  tx_data_q <= wdata_i[BYTE_W-1:0];
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      unique case (addr_i)
        OFF_RXDATA: rdata_o = fifo_empty ? RX_EMPTY_WORD
                                         : {{(REG_W-BYTE_W){1'b0}}, fifo_data};
        OFF_TXCTRL: rdata_o = txctrl_q;
        OFF_RXCTRL: rdata_o = rxctrl_q;
        OFF_IE:     rdata_o = {{(REG_W-IRQ_N){1'b0}}, ie_q};
        OFF_IP:     rdata_o = {{(REG_W-IRQ_N){1'b0}}, ip};
        OFF_DIV:    rdata_o = div_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  // R3
  tx_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx |=> tx_valid_o && tx_data_o == $past(wdata_i[BYTE_W-1:0]));
  // R3
  tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_tx |=> !tx_valid_o);
  // R8
  rx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_ready_o && !fifo_pop) |=> $stable(fifo_count));
  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ie_q[IRQ_TX]) |-> !fifo_empty);
  // R9
  partial_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && be_i != 4'hF) |=> $stable(div_q) && !tx_valid_o);
  // R2
  empty_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && fifo_empty && !rx_valid_i) |=> fifo_empty);
endmodule

// File: tb/test_uart_regif.sv
`timescale 1ns/1ps
module test_uart_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] tx_exp_q [$];

  always #2 clk = ~clk;

  uart_regif i_uart_regif (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_ready_o(rx_ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each transmit strobe
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (tx_exp_q.size() == 0) chk("R3/R9 unexpected tx", {24'h0, tx_data}, 32'hFFFF_FFFF);
      else chk("R3 tx byte", {24'h0, tx_data}, {24'h0, tx_exp_q.pop_front()});
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    if (a == 5'h00 && b == 4'hF) tx_exp_q.push_back(d[7:0]);
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; be = 4'hF;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; be = b;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0; be = 4'hF;
  endtask

  task automatic push(logic [7:0] b, output logic rdy);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 rdy = rx_ready;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic rdy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R7 irq reset", {31'h0, irq}, 32'h0);
    chk("R8 ready reset", {31'h0, rx_ready}, 32'h1);
    rd(5'h14, d); chk("R5 ip reset", d, 32'h0);
    rd(5'h04, d); chk("R2 empty read", d, 32'h8000_0000);
    rd(5'h04, d); chk("R2 empty read again", d, 32'h8000_0000);

    // transmit
    wr(5'h00, 32'h1234_5678);
    wr(5'h00, 32'h0000_00AB);
    wr(5'h00, 32'hFFFF_FF00);
    rd(5'h00, d); chk("R3 txdata reads 0", d, 32'h0);

    // storage
    wr(5'h18, 32'hDEAD_BEEF); rd(5'h18, d); chk("R4 div", d, 32'hDEAD_BEEF);
    wr(5'h08, 32'hA5A0_0001); rd(5'h08, d); chk("R4 txctrl", d, 32'hA5A0_0001);
    wr(5'h0C, 32'h5A58_0003); rd(5'h0C, d); chk("R4 rxctrl", d, 32'h5A58_0003);
    wr(5'h10, 32'hFFFF_FFFC); rd(5'h10, d); chk("R4 ie masked", d, 32'h0);

    // R9: partial, unmapped, read-only
    wr(5'h18, 32'h1111_1111, 4'h3); rd(5'h18, d); chk("R9 partial write", d, 32'hDEAD_BEEF);
    rd(5'h18, d, 4'h7); chk("R9 partial read", d, 32'h0);
    wr(5'h00, 32'h0000_0077, 4'h1);
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, d); chk("R9 unmapped", d, 32'h0);
    wr(5'h14, 32'h3); rd(5'h14, d); chk("R9 ip read-only", d, 32'h0);

    // R5: tx watermark field bits 18:16 (txctrl above has 0 there)
    wr(5'h08, 32'h0001_0000); rd(5'h14, d); chk("R5 tx wm set", d & 32'h1, 32'h1);
    wr(5'h08, 32'hFFF8_FFFF); rd(5'h14, d); chk("R5 tx wm clear", d & 32'h1, 32'h0);

    // R6/R7/R1: receive path
    wr(5'h0C, 32'h0002_0000);
    wr(5'h10, 32'h2);
    chk("R7 rx en, empty", {31'h0, irq}, 32'h0);
    push(8'h11, rdy); push(8'h22, rdy);
    chk("R7 rx en, data", {31'h0, irq}, 32'h1);
    rd(5'h14, d); chk("R6 2 not > 2", d & 32'h2, 32'h0);
    push(8'h33, rdy);
    rd(5'h14, d); chk("R6 3 > 2", d & 32'h2, 32'h2);
    rd(5'h04, d); chk("R1 pop first", d, 32'h11);
    rd(5'h04, d); chk("R1 pop second", d, 32'h22);
    rd(5'h04, d); chk("R1 pop third", d, 32'h33);
    chk("R7 drained", {31'h0, irq}, 32'h0);
    rd(5'h04, d); chk("R2 empty after drain", d, 32'h8000_0000);
    rd(5'h04, d, 4'hC); push(8'h44, rdy);
    rd(5'h04, d); chk("R9/R2 no side effect", d, 32'h44);

    // R8: fill to 8, ninth dropped, wrap pointers
    wr(5'h0C, 32'h0007_0000);
    for (int i = 0; i < 8; i++) begin
      push(8'hA0 + 8'(i), rdy);
      chk("R8 ready while filling", {31'h0, rdy}, 32'h1);
    end
    chk("R8 ready low when full", {31'h0, rx_ready}, 32'h0);
    rd(5'h14, d); chk("R6 8 > 7", d & 32'h2, 32'h2);
    push(8'hEE, rdy);
    chk("R8 offered while full", {31'h0, rdy}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, d); chk("R8/R1 drain order", d, 32'hA0 + i);
    end
    rd(5'h04, d); chk("R8 dropped byte absent", d, 32'h8000_0000);

    // R7: tx enable alone raises irq
    wr(5'h10, 32'h1);
    chk("R7 tx en", {31'h0, irq}, 32'h1);
    rd(5'h10, d); chk("R4 ie readback", d, 32'h1);
    wr(5'h10, 32'h0);
    chk("R7 all off", {31'h0, irq}, 32'h0);

    repeat (3) @(negedge clk);
    chk("R3 scoreboard empty", tx_exp_q.size(), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule